// File: doc/BRIEF.md
# I2C Slave Controller with 7-bit and 10-bit Addressing

This block is an I2C target (slave) controller clocked by a fast system clock. It watches the open-drain SCL and SDA wires through a two-flop synchronizer and detects START and STOP conditions on them. Each byte that follows a START is matched against a static own address. The address is 7-bit or 10-bit, chosen by a static mode input. Matched address bytes and all write data bytes are acknowledged. Written bytes are handed to the user side through a valid/ready port. Bytes for a read are fetched from the user side through a second valid/ready port.

The controller pulls a wire low only through its two output-enable pins: `sda_oe` and `scl_oe`. A high output enable pulls the wire low. The controller holds SCL low, and so stalls the bus, in two cases. On a read it holds SCL whenever it still needs a byte to send. On a write it holds SCL only when `rx_stretch_en` is set and the last byte has not been taken. A 10-bit read uses the usual sequence: a write header, the low address byte, a repeated START, and then the header with the read bit set.

Top module: `i2c_dual_addr_slave`

## Requirements
- R1: With `ten_bit_mode`=0, the controller pulls SDA low on the ninth clock of the first byte after START when bits 7..1 of that byte equal `own_addr[6:0]`. Bit 0 is the read flag (1 = read). On a mismatch it leaves SDA released for the rest of the transfer.
- R2: With `ten_bit_mode`=1, a first byte of the form `11110 A9 A8 0` is acknowledged only when A9,A8 equal `own_addr[9:8]`.
- R3: In 10-bit mode, the byte after an acknowledged write header is acknowledged only when it equals `own_addr[7:0]`. Otherwise SDA stays released.
- R4: After an address match with the read flag at 0, every later byte is received MSB first and acknowledged, with no limit on the count. Each byte appears on `rx_data` with `rx_valid` from the falling SCL edge that ends its eighth bit.
- R5: `rx_valid` stays high until a cycle with `rx_ready` high. If the byte is not taken and stretching is off, the next byte replaces it.
- R6: With `rx_stretch_en`=1, the controller holds SCL low after the acknowledge clock while a received byte is still untaken. It releases SCL once the byte is taken or the enable drops. With `rx_stretch_en`=0 it never holds SCL on a write.
- R7: After an acknowledged read address, and after each byte the master acknowledges, the controller holds SCL low with `tx_ready` high until `tx_valid`. It then sends the byte MSB first, driving SDA low for each 0 bit.
- R8: When the master answers a sent byte with a not-acknowledge (SDA high on the ninth clock), the controller releases SDA and requests no further byte until the next START.
- R9: When the master acknowledges a sent byte, the next byte is requested and sent in the same transfer.
- R10: In 10-bit mode, a read header `11110 A9 A8 1` is acknowledged only after a matched full 10-bit write address since the last STOP. Otherwise it is not acknowledged.
- R11: STOP (SDA rising while SCL is high) returns the controller to idle with both lines released, from any point in a transfer. A START at any point restarts address matching from bit 0.
- R12: `sda_oe` changes only while SCL is low. `scl_oe` is high only while the controller is stalling for the user side.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | SCL wire level |
| sda_i | input | 1 | SDA wire level |
| scl_oe | output | 1 | 1 pulls SCL low (clock stretch) |
| sda_oe | output | 1 | 1 pulls SDA low (ack or data 0) |
| own_addr | input | 10 | Own address; bits 6..0 used in 7-bit mode |
| ten_bit_mode | input | 1 | 1 selects 10-bit address matching |
| rx_stretch_en | input | 1 | Allows SCL hold while a write byte is untaken |
| rx_data | output | 8 | Last received write byte |
| rx_valid | output | 1 | Received byte waiting |
| rx_ready | input | 1 | User takes the received byte |
| tx_data | input | 8 | Byte to send on a read |
| tx_valid | input | 1 | tx_data is present |
| tx_ready | output | 1 | Controller needs a byte to send |

## Verification
The two synchronizer flops and the edge-detect flop put every SCL or SDA change three clocks behind the wire. For example, `sda_oe` moves at the third rising clock after SCL falls, and a received byte shows on `rx_valid` at that same clock. The bench master holds each SCL phase for 20 clocks and reads SDA at the end of the high phase, so an acknowledge or data bit is sampled well after it has settled. Handshake effects come one clock after the accepting edge. User-side checks wait at least 100 clocks into a stall before reading `scl_oe` and `rx_data`. All sampling happens on the falling clock edge.

// File: rtl/i2c_slv_pkg.sv
package i2c_slv_pkg;
    localparam int BYTE_W = 8;
    localparam int CNT_W  = 4;
    localparam int ADDR_W = 10;
    localparam logic [4:0] TEN_HDR = 5'b11110;
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);

    typedef enum logic [2:0] {
        ST_IDLE, ST_RECV, ST_ACK, ST_SEND,
        ST_MACK, ST_HOLD_TX, ST_HOLD_RX, ST_IGNORE
    } st_e;

    // meaning of the byte being received, or what follows the ack
    typedef enum logic [1:0] {BK_ADDR1, BK_ADDR2, BK_DATA, BK_READ} bk_e;

    typedef struct packed {
        st_e               st;
        bk_e               bk;
        logic [CNT_W-1:0]  cnt;
        logic [BYTE_W-1:0] sh;
        logic              sda_drv;
        logic              ten_ok;
        logic              mack;
        logic [BYTE_W-1:0] rx_buf;
        logic              rx_vld;
    } regs_t;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic line_s,
    output logic line_p
);
    logic [STAGES-1:0] chain_d, chain_q;
    logic              prev_d, prev_q;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], line_i};
        prev_d  = chain_q[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '1;
            prev_q  <= 1'b1;
        end else begin
            chain_q <= chain_d;
            prev_q  <= prev_d;
        end
    end

    assign line_s = chain_q[STAGES-1];
    assign line_p = prev_q;
endmodule

// File: rtl/i2c_addr_cmp.sv
module i2c_addr_cmp
    import i2c_slv_pkg::*;
(
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              ten_bit_mode,
    output logic              hit7,
    output logic              hdr_hit,
    output logic              low_hit
);
    always_comb begin
        hit7    = !ten_bit_mode && (rx_byte[BYTE_W-1:1] == own_addr[6:0]);
        hdr_hit = ten_bit_mode && (rx_byte[BYTE_W-1:3] == TEN_HDR)
                  && (rx_byte[2:1] == own_addr[ADDR_W-1:ADDR_W-2]);
        low_hit = ten_bit_mode && (rx_byte == own_addr[BYTE_W-1:0]);
    end
endmodule

// File: rtl/i2c_dual_addr_slave.sv
module i2c_dual_addr_slave
    import i2c_slv_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              scl_oe,
    output logic              sda_oe,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              ten_bit_mode,
    input  logic              rx_stretch_en,
    output logic [BYTE_W-1:0] rx_data,
    output logic              rx_valid,
    input  logic              rx_ready,
    input  logic [BYTE_W-1:0] tx_data,
    input  logic              tx_valid,
    output logic              tx_ready
);
    logic [1:0] raw_w, syn_w, prv_w;
    assign raw_w = {sda_i, scl_i};

    for (genvar g = 0; g < 2; g++) begin : g_line
        i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk    (clk),
            .rst_n  (rst_n),
            .line_i (raw_w[g]),
            .line_s (syn_w[g]),
            .line_p (prv_w[g])
        );
    end

    logic scl_s, scl_p, sda_s, sda_p;
    logic scl_rise, scl_fall, start_det, stop_det;
    assign scl_s = syn_w[0];
    assign scl_p = prv_w[0];
    assign sda_s = syn_w[1];
    assign sda_p = prv_w[1];
    assign scl_rise  = scl_s & ~scl_p;
    assign scl_fall  = ~scl_s & scl_p;
    // SCL must be high on both samples so a data change at SCL release is not a START
    assign start_det = scl_s & scl_p & sda_p & ~sda_s;
    assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;

    regs_t r_q, r_d;
    logic  hit7, hdr_hit, low_hit, ack_ok;

    i2c_addr_cmp u_cmp (
        .rx_byte      (r_q.sh),
        .own_addr     (own_addr),
        .ten_bit_mode (ten_bit_mode),
        .hit7         (hit7),
        .hdr_hit      (hdr_hit),
        .low_hit      (low_hit)
    );

    always_comb begin
        r_d    = r_q;
        ack_ok = 1'b0;
        if (r_q.rx_vld && rx_ready) r_d.rx_vld = 1'b0;

        if (stop_det) begin
            r_d.st      = ST_IDLE;
            r_d.sda_drv = 1'b0;
            r_d.ten_ok  = 1'b0;
            r_d.cnt     = '0;
        end else if (start_det) begin
            r_d.st      = ST_RECV;
            r_d.bk      = BK_ADDR1;
            r_d.sda_drv = 1'b0;
            r_d.cnt     = '0;
        end else begin
            unique case (r_q.st)
                ST_RECV: begin
                    if (scl_rise && r_q.cnt != LAST_BIT) begin
                        r_d.sh  = {r_q.sh[BYTE_W-2:0], sda_s};
                        r_d.cnt = r_q.cnt + 1'b1;
                    end else if (scl_fall && r_q.cnt == LAST_BIT) begin
                        r_d.cnt = '0;
                        unique case (r_q.bk)
                            BK_ADDR1: begin
                                if (!r_q.sh[0]) r_d.ten_ok = 1'b0;
                                if (!ten_bit_mode) begin
                                    ack_ok = hit7;
                                    r_d.bk = r_q.sh[0] ? BK_READ : BK_DATA;
                                end else if (!r_q.sh[0]) begin
                                    ack_ok = hdr_hit;
                                    r_d.bk = BK_ADDR2;
                                end else begin
                                    ack_ok = hdr_hit && r_q.ten_ok;
                                    r_d.bk = BK_READ;
                                end
                            end
                            BK_ADDR2: begin
                                ack_ok     = low_hit;
                                r_d.ten_ok = low_hit;
                                r_d.bk     = BK_DATA;
                            end
                            default: begin
                                ack_ok     = 1'b1;
                                r_d.rx_buf = r_q.sh;
                                r_d.rx_vld = 1'b1;
                            end
                        endcase
                        r_d.st      = ack_ok ? ST_ACK : ST_IGNORE;
                        r_d.sda_drv = ack_ok;
                    end
                end
                ST_ACK: begin
                    if (scl_fall) begin
                        r_d.sda_drv = 1'b0;
                        if (r_q.bk == BK_READ)
                            r_d.st = ST_HOLD_TX;
                        else if (r_q.bk == BK_DATA && rx_stretch_en && r_q.rx_vld && !rx_ready)
                            r_d.st = ST_HOLD_RX;
                        else
                            r_d.st = ST_RECV;
                    end
                end
                ST_HOLD_RX: begin
                    if (!r_q.rx_vld || rx_ready || !rx_stretch_en) r_d.st = ST_RECV;
                end
                ST_HOLD_TX: begin
                    if (tx_valid) begin
                        r_d.sh      = tx_data;
                        r_d.sda_drv = ~tx_data[BYTE_W-1];
                        r_d.cnt     = CNT_W'(1);
                        r_d.st      = ST_SEND;
                    end
                end
                ST_SEND: begin
                    if (scl_fall) begin
                        if (r_q.cnt == LAST_BIT) begin
                            r_d.sda_drv = 1'b0;
                            r_d.cnt     = '0;
                            r_d.st      = ST_MACK;
                        end else begin
                            r_d.sh      = {r_q.sh[BYTE_W-2:0], 1'b0};
                            r_d.sda_drv = ~r_q.sh[BYTE_W-2];
                            r_d.cnt     = r_q.cnt + 1'b1;
                        end
                    end
                end
                ST_MACK: begin
                    if (scl_rise)
                        r_d.mack = ~sda_s;
                    else if (scl_fall)
                        r_d.st = r_q.mack ? ST_HOLD_TX : ST_IGNORE;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, bk: BK_ADDR1, cnt: '0, sh: '0, sda_drv: 1'b0,
                     ten_ok: 1'b0, mack: 1'b0, rx_buf: '0, rx_vld: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign sda_oe   = r_q.sda_drv;
    assign scl_oe   = (r_q.st == ST_HOLD_TX) || (r_q.st == ST_HOLD_RX);
    assign tx_ready = (r_q.st == ST_HOLD_TX);
    assign rx_data  = r_q.rx_buf;
    assign rx_valid = r_q.rx_vld;
endmodule

// File: rtl/i2c_dual_addr_slave_chk.sv
module i2c_dual_addr_slave_chk (
    input logic clk,
    input logic rst_n,
    input logic scl_i,
    input logic scl_oe,
    input logic sda_oe,
    input logic rx_valid,
    input logic rx_ready,
    input logic tx_valid,
    input logic tx_ready
);
    assert_rx_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !rx_ready) |=> rx_valid);

    assert_tx_wait_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_ready && !tx_valid) |=> tx_ready);

    assert_scl_only_stall_R12: assert property (@(posedge clk) disable iff (!rst_n)
        scl_oe |-> (tx_ready || rx_valid));

    assert_sda_moves_scl_low_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !$past(scl_i));

    assert_stall_sda_free_R6: assert property (@(posedge clk) disable iff (!rst_n)
        scl_oe |-> !sda_oe);
endmodule

bind i2c_dual_addr_slave i2c_dual_addr_slave_chk chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (scl_i),
    .scl_oe   (scl_oe),
    .sda_oe   (sda_oe),
    .rx_valid (rx_valid),
    .rx_ready (rx_ready),
    .tx_valid (tx_valid),
    .tx_ready (tx_ready)
);

// File: tb/i2c_dual_addr_slave_tb_top.sv
module i2c_dual_addr_slave_tb_top;
    localparam int H  = 20;
    localparam int NV = 8;
    // {ten, own_addr[9:0], byte1, byte2, ack1 expected, ack2 expected}
    localparam logic [28:0] VEC [NV] = '{
        {1'b0, 10'h02A, 8'h54, 8'hA5, 1'b1, 1'b1},
        {1'b0, 10'h02A, 8'h56, 8'h00, 1'b0, 1'b0},
        {1'b1, 10'h2B5, 8'hF4, 8'hB5, 1'b1, 1'b1},
        {1'b1, 10'h2B5, 8'hF2, 8'hB5, 1'b0, 1'b0},
        {1'b1, 10'h2B5, 8'hF4, 8'hB4, 1'b1, 1'b0},
        {1'b0, 10'h07A, 8'hF4, 8'h3C, 1'b1, 1'b1},
        {1'b1, 10'h07A, 8'hF0, 8'h7A, 1'b1, 1'b1},
        {1'b1, 10'h07A, 8'hF1, 8'h00, 1'b0, 1'b0}
    };

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic       rst_n;
    logic       m_scl_low, m_sda_low;
    logic       scl_oe, sda_oe;
    logic [9:0] own_addr;
    logic       ten_bit_mode, rx_stretch_en;
    logic [7:0] rx_data, tx_data;
    logic       rx_valid, rx_ready, tx_valid, tx_ready;
    wire        scl_line = !(m_scl_low || scl_oe);
    wire        sda_line = !(m_sda_low || sda_oe);

    i2c_dual_addr_slave dut_i (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(sda_line),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .own_addr(own_addr),
        .ten_bit_mode(ten_bit_mode), .rx_stretch_en(rx_stretch_en),
        .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready)
    );

    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;
    int hold_cnt = 0;
    logic [7:0] last_rx = 8'h00;
    logic [7:0] tx_mem [4] = '{8'hC3, 8'h5A, 8'h96, 8'h0F};
    int tx_idx = 0;
    int stall = 0;

    always @(posedge clk) begin
        if (scl_oe) hold_cnt <= hold_cnt + 1;
        if (rx_valid && rx_ready) last_rx <= rx_data;
    end

    // read-data supplier: answers tx_ready after a 30-cycle stall
    initial begin
        tx_valid = 1'b0;
        tx_data  = 8'h00;
        forever begin
            @(negedge clk);
            if (tx_valid) tx_valid = 1'b0;
            else if (tx_ready) begin
                if (stall == 30) begin
                    tx_valid = 1'b1;
                    tx_data  = tx_mem[tx_idx];
                    tx_idx++;
                    stall = 0;
                end else stall++;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    task automatic wait_h();
        repeat (H) @(negedge clk);
    endtask

    task automatic clk_bit(input logic b, output logic r);
        m_sda_low = !b;
        wait_h();
        m_scl_low = 1'b0;
        wait (scl_line == 1'b1);
        wait_h();
        r = sda_line;
        m_scl_low = 1'b1;
        wait_h();
    endtask

    task automatic m_start();
        m_sda_low = 1'b0;
        wait_h();
        m_scl_low = 1'b0;
        wait (scl_line == 1'b1);
        wait_h();
        m_sda_low = 1'b1;
        wait_h();
        m_scl_low = 1'b1;
        wait_h();
    endtask

    task automatic m_stop();
        m_sda_low = 1'b1;
        wait_h();
        m_scl_low = 1'b0;
        wait (scl_line == 1'b1);
        wait_h();
        m_sda_low = 1'b0;
        wait_h();
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        logic r;
        for (int i = 7; i >= 0; i--) clk_bit(b[i], r);
        clk_bit(1'b1, r);
        acked = !r;
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] b);
        logic r;
        b = 8'h00;
        for (int i = 0; i < 8; i++) begin
            clk_bit(1'b1, r);
            b = {b[6:0], r};
        end
        clk_bit(!give_ack, r);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual=%0h expected=%0h", 0, 1);
            report();
            $finish;
        end
    end

    initial begin
        logic       a;
        logic [7:0] b;
        int         snap;
        rst_n = 1'b0; m_scl_low = 1'b0; m_sda_low = 1'b0;
        own_addr = 10'h02A; ten_bit_mode = 1'b0;
        rx_stretch_en = 1'b0; rx_ready = 1'b1;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // reset state (R11)
        chk(!scl_oe && !sda_oe, "R11", "reset lines released", {scl_oe, sda_oe}, 0);
        chk(!rx_valid && !tx_ready, "R11", "reset handshakes idle", {rx_valid, tx_ready}, 0);

        // address-match vector table
        for (int v = 0; v < NV; v++) begin
            logic [28:0] e;
            e = VEC[v];
            ten_bit_mode = e[28];
            own_addr = e[27:18];
            m_start();
            send_byte(e[17:10], a);
            chk(a == e[1], e[28] ? "R2" : "R1", $sformatf("vec%0d ack1", v), a, e[1]);
            if (e[1]) begin
                send_byte(e[9:2], a);
                chk(a == e[0], e[28] ? "R3" : "R4", $sformatf("vec%0d ack2", v), a, e[0]);
                if (!e[28]) begin
                    repeat (4) @(negedge clk);
                    chk(last_rx == e[9:2], "R4", $sformatf("vec%0d rx byte", v), last_rx, e[9:2]);
                end
            end
            m_stop();
        end

        // R6 / R5: write stall while the byte is untaken
        ten_bit_mode = 1'b0; own_addr = 10'h02A;
        rx_stretch_en = 1'b1; rx_ready = 1'b0;
        m_start();
        send_byte(8'h54, a);
        send_byte(8'h11, a);
        chk(a, "R4", "first data ack", a, 1);
        fork
            send_byte(8'h22, a);
            begin
                repeat (150) @(negedge clk);
                chk(scl_oe, "R6", "SCL held for untaken byte", scl_oe, 1);
                chk(rx_valid && rx_data == 8'h11, "R5", "byte held while stalled", rx_data, 8'h11);
                rx_ready = 1'b1;
                @(negedge clk);
                rx_ready = 1'b0;
            end
        join
        chk(a, "R6", "ack after stall released", a, 1);
        rx_stretch_en = 1'b0;
        repeat (10) @(negedge clk);
        snap = hold_cnt;
        send_byte(8'h33, a);
        chk(hold_cnt == snap, "R6", "no stall when enable low", hold_cnt - snap, 0);
        chk(rx_valid && rx_data == 8'h33, "R5", "untaken byte overwritten", rx_data, 8'h33);
        m_stop();
        rx_ready = 1'b1;
        repeat (5) @(negedge clk);

        // R7 / R9 / R8: 7-bit read
        snap = hold_cnt;
        m_start();
        send_byte(8'h55, a);
        chk(a, "R1", "read address ack", a, 1);
        recv_byte(1'b1, b);
        chk(b == 8'hC3, "R7", "first read byte", b, 8'hC3);
        chk(hold_cnt - snap >= 30, "R7", "SCL held until data", hold_cnt - snap, 30);
        recv_byte(1'b0, b);
        chk(b == 8'h5A, "R9", "second read byte after ack", b, 8'h5A);
        recv_byte(1'b0, b);
        chk(b == 8'hFF, "R8", "SDA released after nack", b, 8'hFF);
        chk(tx_idx == 2, "R8", "no byte requested after nack", tx_idx, 2);
        m_stop();
        repeat (5) @(negedge clk);
        chk(!scl_oe && !sda_oe && !tx_ready, "R11", "idle after stop", {scl_oe, sda_oe, tx_ready}, 0);

        // R10: 10-bit read via repeated START
        ten_bit_mode = 1'b1; own_addr = 10'h2B5;
        m_start();
        send_byte(8'hF4, a);
        send_byte(8'hB5, a);
        m_start();
        send_byte(8'hF5, a);
        chk(a, "R10", "read header after full match", a, 1);
        recv_byte(1'b0, b);
        chk(b == 8'h96, "R10", "10-bit read byte", b, 8'h96);
        m_stop();
        m_start();
        send_byte(8'hF5, a);
        chk(!a, "R10", "read header without prior match", a, 0);
        m_stop();

        // R11: repeated START in the middle of a data byte
        ten_bit_mode = 1'b0; own_addr = 10'h02A;
        m_start();
        send_byte(8'h54, a);
        for (int i = 0; i < 4; i++) clk_bit(1'b0, a);
        m_start();
        send_byte(8'h54, a);
        chk(a, "R11", "address after mid-byte restart", a, 1);
        send_byte(8'h77, a);
        repeat (4) @(negedge clk);
        chk(last_rx == 8'h77, "R11", "data after restart", last_rx, 8'h77);
        m_stop();

        done = 1'b1;
        report();
        $finish;
    end
endmodule